// File: doc/BRIEF.md
# Fair Priority Thread Scheduler

This block picks the next thread to run for a hardware kernel. Threads are marked ready in a bit vector held inside the block. Each thread's descriptor sits in an external single-port thread control memory. A pulse on `start` begins one scheduling pass. The block walks the ready threads in ascending ID order and reads each descriptor. It keeps the best candidate by the combined key {priority, wait count}. On `done` it reports the winner's ID and priority with a valid flag.

A second walk over the same threads updates the wait counters. This lets threads that share a priority level take turns, and keeps the counters from creeping upward. All traffic goes through one memory port, so the descriptor store can be a register file, an SRAM or a slow DRAM.

Each descriptor word has four fields, from bit 0 upward:
- the wait count (TID_W bits);
- the priority (PRIO_W bits);
- a link ID (TID_W bits);
- a link flag (1 bit).

With the defaults these occupy [2:0], [6:3], [9:7] and [10]. The scheduler reads the link fields but never changes them.

Top module: `fair_thread_sched`

## Requirements
- R1: A bit set in `rdy_set` sets the matching bit of `ready_vec` on the next clock. A bit set in `rdy_clr` clears it. When both are set for the same thread, the clear wins.
- R2: After a pass with at least one valid ready thread, `sel_valid` is 1. `sel_tid` is the ready thread whose key {priority field, wait count field} is largest as an unsigned number, and `sel_prio` is its priority field.
- R3: When two ready valid threads have equal keys, the lower thread ID wins.
- R4: A thread whose priority field is 0 is invalid and is never selected. `sel_prio` is never 0 while `sel_valid` is 1.
- R5: When no thread is ready, or every ready thread is invalid, `done` still pulses with `sel_valid` at 0, and no descriptor is written.
- R6: After a pass with a winner, the winner's wait count is 0. Every other ready thread with the winner's priority has its wait count incremented by one, saturating at the all-ones value. Ready threads of other priorities keep their count. The priority and link fields of every descriptor are unchanged.
- R7: When every ready thread had a nonzero wait count at the start of a pass that has a winner, each ready thread's count is first decremented by one, and R6 is then applied. Same-priority peers therefore keep their value.
- R8: The block accesses only the descriptors of threads that were ready when the pass began. A pass with a winner makes three accesses per ready thread: one read in the first walk, then a read and a write of the same address in the second. A pass without a winner makes one read per ready thread. Every write goes to the address read in the cycle just before it.
- R9: `done` is a single-cycle pulse, and there is exactly one pulse per accepted `start`. A `start` that arrives during a pass is ignored. `sel_valid`, `sel_tid` and `sel_prio` change only in the cycle where `done` is high.
- R10: Changes to the ready bits during a pass do not affect that pass. They do appear on `ready_vec` and take effect in the next pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a scheduling pass (accepted when idle) |
| done | output | 1 | One-cycle pulse at the end of a pass |
| rdy_set | input | NUM_THREADS | Per-thread ready set |
| rdy_clr | input | NUM_THREADS | Per-thread ready clear (has priority over set) |
| ready_vec | output | NUM_THREADS | Current ready bit vector |
| mem_en | output | 1 | Descriptor memory access enable |
| mem_we | output | 1 | Descriptor memory write (read when low) |
| mem_addr | output | TID_W | Descriptor address (thread ID) |
| mem_wdata | output | DESC_W | Descriptor write data |
| mem_rdata | input | DESC_W | Descriptor read data, valid the cycle after a read |
| sel_valid | output | 1 | A valid thread was selected by the last pass |
| sel_tid | output | TID_W | Selected thread ID |
| sel_prio | output | PRIO_W | Priority field of the selected thread |

## Verification
The bound checker watches several properties on every cycle:
- the ready vector obeys set and clear with clear winning;
- `done` never lasts more than one cycle;
- the selection outputs hold still except at `done`;
- a valid selection never reports priority 0;
- each descriptor write lands on the address read just before it.

Some behaviour shows only over whole passes, so only the bench's scenarios can demonstrate it: which thread wins, tie breaking, counter reset, increment, saturation and global decrement, the number of accesses, and that a pass is unaffected by ready changes and by a second `start`. A model of the rules in the bench predicts these and compares them against the memory contents after each `done`.

// File: rtl/sched_pkg.sv
package sched_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_RD1  = 3'd1,
        ST_EV1  = 3'd2,
        ST_TURN = 3'd3,
        ST_RD2  = 3'd4,
        ST_WR2  = 3'd5,
        ST_FIN  = 3'd6
    } sched_state_e;

endpackage

// File: rtl/sched_ready_vec.sv
module sched_ready_vec #(
    parameter int NUM_THREADS = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_THREADS-1:0] set_i,
    input  logic [NUM_THREADS-1:0] clr_i,
    output logic [NUM_THREADS-1:0] vec_o
);

    logic [NUM_THREADS-1:0] vec_d, vec_q;

    always_comb begin
        vec_d = (vec_q | set_i) & ~clr_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) vec_q <= '0;
        else        vec_q <= vec_d;
    end

    assign vec_o = vec_q;

endmodule

// File: rtl/sched_key_cmp.sv
module sched_key_cmp #(
    parameter int PRIO_W = 4,
    parameter int WCNT_W = 3,
    localparam int KEY_W = PRIO_W + WCNT_W
) (
    input  logic [PRIO_W-1:0] cand_prio,
    input  logic [WCNT_W-1:0] cand_wcnt,
    input  logic              have_best,
    input  logic [KEY_W-1:0]  best_key,
    output logic              take
);

    logic [KEY_W-1:0] cand_key;

    always_comb begin
        cand_key = {cand_prio, cand_wcnt};
        // strict compare keeps the earlier (lower) ID on a tie
        take = (cand_prio != '0) && (!have_best || (cand_key > best_key));
    end

endmodule

// File: rtl/sched_wcnt_upd.sv
module sched_wcnt_upd #(
    parameter int PRIO_W = 4,
    parameter int WCNT_W = 3
) (
    input  logic [WCNT_W-1:0] old_wcnt,
    input  logic [PRIO_W-1:0] cand_prio,
    input  logic [PRIO_W-1:0] win_prio,
    input  logic              is_winner,
    input  logic              dec_all,
    output logic [WCNT_W-1:0] new_wcnt
);

    localparam logic [WCNT_W-1:0] WMAX = '1;

    logic [WCNT_W-1:0] base;

    always_comb begin
        base = dec_all ? (old_wcnt - 1'b1) : old_wcnt;
        if (is_winner)
            new_wcnt = '0;
        else if (cand_prio == win_prio)
            new_wcnt = (base == WMAX) ? WMAX : (base + 1'b1);
        else
            new_wcnt = base;
    end

endmodule

// File: rtl/fair_thread_sched.sv
module fair_thread_sched #(
    parameter int NUM_THREADS = 8,
    parameter int PRIO_W      = 4,
    localparam int TID_W      = $clog2(NUM_THREADS),
    localparam int KEY_W      = PRIO_W + TID_W,
    localparam int DESC_W     = 1 + 2 * TID_W + PRIO_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    output logic                   done,
    input  logic [NUM_THREADS-1:0] rdy_set,
    input  logic [NUM_THREADS-1:0] rdy_clr,
    output logic [NUM_THREADS-1:0] ready_vec,
    output logic                   mem_en,
    output logic                   mem_we,
    output logic [TID_W-1:0]       mem_addr,
    output logic [DESC_W-1:0]      mem_wdata,
    input  logic [DESC_W-1:0]      mem_rdata,
    output logic                   sel_valid,
    output logic [TID_W-1:0]       sel_tid,
    output logic [PRIO_W-1:0]      sel_prio
);
    import sched_pkg::*;

    typedef struct packed {
        sched_state_e           st;
        logic [NUM_THREADS-1:0] snap;
        logic [TID_W-1:0]       idx;
        logic                   best_v;
        logic [TID_W-1:0]       best_id;
        logic [KEY_W-1:0]       best_key;
        logic                   all_pos;
        logic                   sel_v;
        logic [TID_W-1:0]       sel_id;
        logic [PRIO_W-1:0]      sel_p;
    } regs_t;

    regs_t r_d, r_q;

    logic [TID_W-1:0]  rd_wcnt;
    logic [PRIO_W-1:0] rd_prio;
    logic [TID_W-1:0]  new_wcnt;
    logic              take;
    logic              at_last;
    logic              is_win;

    assign rd_wcnt = mem_rdata[TID_W-1:0];
    assign rd_prio = mem_rdata[TID_W +: PRIO_W];
    assign at_last = (r_q.idx == TID_W'(NUM_THREADS - 1));
    assign is_win  = r_q.best_v && (r_q.idx == r_q.best_id);

    sched_ready_vec #(.NUM_THREADS(NUM_THREADS)) u_ready (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (rdy_set),
        .clr_i (rdy_clr),
        .vec_o (ready_vec)
    );

    sched_key_cmp #(.PRIO_W(PRIO_W), .WCNT_W(TID_W)) u_cmp (
        .cand_prio (rd_prio),
        .cand_wcnt (rd_wcnt),
        .have_best (r_q.best_v),
        .best_key  (r_q.best_key),
        .take      (take)
    );

    sched_wcnt_upd #(.PRIO_W(PRIO_W), .WCNT_W(TID_W)) u_upd (
        .old_wcnt  (rd_wcnt),
        .cand_prio (rd_prio),
        .win_prio  (r_q.best_key[KEY_W-1 -: PRIO_W]),
        .is_winner (is_win),
        .dec_all   (r_q.all_pos),
        .new_wcnt  (new_wcnt)
    );

    always_comb begin
        r_d       = r_q;
        done      = 1'b0;
        mem_en    = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = r_q.idx;
        mem_wdata = {mem_rdata[DESC_W-1:TID_W], new_wcnt};

        case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.st       = ST_RD1;
                    r_d.snap     = ready_vec;
                    r_d.idx      = '0;
                    r_d.best_v   = 1'b0;
                    r_d.best_id  = '0;
                    r_d.best_key = '0;
                    r_d.all_pos  = 1'b1;
                end
            end
            ST_RD1: begin
                if (r_q.snap[r_q.idx]) begin
                    mem_en = 1'b1;
                    r_d.st = ST_EV1;
                end else if (at_last) begin
                    r_d.st = ST_TURN;
                end else begin
                    r_d.idx = r_q.idx + 1'b1;
                end
            end
            ST_EV1: begin
                if (rd_wcnt == '0) r_d.all_pos = 1'b0;
                if (take) begin
                    r_d.best_v   = 1'b1;
                    r_d.best_id  = r_q.idx;
                    r_d.best_key = {rd_prio, rd_wcnt};
                end
                if (at_last) begin
                    r_d.st = ST_TURN;
                end else begin
                    r_d.idx = r_q.idx + 1'b1;
                    r_d.st  = ST_RD1;
                end
            end
            ST_TURN: begin
                if (r_q.best_v) begin
                    r_d.idx = '0;
                    r_d.st  = ST_RD2;
                end else begin
                    r_d.st = ST_FIN;
                end
            end
            ST_RD2: begin
                if (r_q.snap[r_q.idx]) begin
                    mem_en = 1'b1;
                    r_d.st = ST_WR2;
                end else if (at_last) begin
                    r_d.st = ST_FIN;
                end else begin
                    r_d.idx = r_q.idx + 1'b1;
                end
            end
            ST_WR2: begin
                mem_en = 1'b1;
                mem_we = 1'b1;
                if (at_last) begin
                    r_d.st = ST_FIN;
                end else begin
                    r_d.idx = r_q.idx + 1'b1;
                    r_d.st  = ST_RD2;
                end
            end
            ST_FIN: begin
                done   = 1'b1;
                r_d.st = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase

        if (r_d.st == ST_FIN && r_q.st != ST_FIN) begin
            r_d.sel_v  = r_d.best_v;
            r_d.sel_id = r_d.best_id;
            r_d.sel_p  = r_d.best_key[KEY_W-1 -: PRIO_W];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign sel_valid = r_q.sel_v;
    assign sel_tid   = r_q.sel_id;
    assign sel_prio  = r_q.sel_p;

endmodule

// File: rtl/fair_thread_sched_chk.sv
module fair_thread_sched_chk #(
    parameter int NUM_THREADS = 8,
    parameter int PRIO_W      = 4,
    localparam int TID_W      = $clog2(NUM_THREADS),
    localparam int DESC_W     = 1 + 2 * TID_W + PRIO_W
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   start,
    input logic                   done,
    input logic [NUM_THREADS-1:0] rdy_set,
    input logic [NUM_THREADS-1:0] rdy_clr,
    input logic [NUM_THREADS-1:0] ready_vec,
    input logic                   mem_en,
    input logic                   mem_we,
    input logic [TID_W-1:0]       mem_addr,
    input logic [DESC_W-1:0]      mem_wdata,
    input logic [DESC_W-1:0]      mem_rdata,
    input logic                   sel_valid,
    input logic [TID_W-1:0]       sel_tid,
    input logic [PRIO_W-1:0]      sel_prio
);

    // R1
    clr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_vec & $past(rdy_clr)) == '0);

    // R1
    set_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((ready_vec & $past(rdy_set & ~rdy_clr)) == $past(rdy_set & ~rdy_clr)));

    // R4
    valid_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_valid |-> (sel_prio != '0));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable({sel_valid, sel_tid, sel_prio}));

    // R8
    write_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && mem_we) |-> ($past(mem_en) && !$past(mem_we) && ($past(mem_addr) == mem_addr)));

endmodule

bind fair_thread_sched fair_thread_sched_chk #(
    .NUM_THREADS(NUM_THREADS),
    .PRIO_W(PRIO_W)
) u_chk (.*);

// File: tb/fair_thread_sched_test.sv
module fair_thread_sched_test;
    localparam int NT = 8;
    localparam int PW = 4;
    localparam int TW = 3;
    localparam int DW = 1 + 2 * TW + PW;

    typedef struct {
        logic           v;
        logic [TW-1:0]  tid;
        logic [PW-1:0]  prio;
        logic [NT*DW-1:0] mem;
        int             acc;
        string          req;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic done;
    logic [NT-1:0] rdy_set = '0;
    logic [NT-1:0] rdy_clr = '0;
    logic [NT-1:0] ready_vec;
    logic mem_en, mem_we;
    logic [TW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata = '0;
    logic sel_valid;
    logic [TW-1:0] sel_tid;
    logic [PW-1:0] sel_prio;

    logic [DW-1:0] mem [NT];
    logic          tb_we = 1'b0;
    logic [TW-1:0] tb_addr = '0;
    logic [DW-1:0] tb_data = '0;
    logic [NT-1:0] run_ready = '0;
    int acc_total = 0, acc_mark = 0, bad_total = 0, bad_mark = 0;
    int n_chk = 0, n_err = 0;
    exp_t exp_q[$];

    always #5 clk = ~clk;

    fair_thread_sched #(.NUM_THREADS(NT), .PRIO_W(PW)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .done(done),
        .rdy_set(rdy_set), .rdy_clr(rdy_clr), .ready_vec(ready_vec),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .sel_valid(sel_valid), .sel_tid(sel_tid), .sel_prio(sel_prio)
    );

    // behavioural descriptor store, one port, read data one cycle later
    always @(posedge clk) begin
        if (mem_en) begin
            acc_total <= acc_total + 1;
            if (!run_ready[mem_addr]) bad_total <= bad_total + 1;
            if (mem_we) mem[mem_addr] <= mem_wdata;
            else        mem_rdata <= mem[mem_addr];
        end else if (tb_we) begin
            mem[tb_addr] <= tb_data;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [127:0] act, input logic [127:0] expv);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    function automatic logic [DW-1:0] mk(input logic n, input logic [TW-1:0] nx,
                                         input logic [PW-1:0] p, input logic [TW-1:0] w);
        return {n, nx, p, w};
    endfunction

    function automatic logic [NT*DW-1:0] pack_mem();
        logic [NT*DW-1:0] r;
        for (int k = 0; k < NT; k++) r[k*DW +: DW] = mem[k];
        return r;
    endfunction

    // rules of R2..R8 applied to the current store
    function automatic exp_t model(input logic [NT-1:0] rdy, input string req);
        exp_t e;
        int best = -1;
        logic [PW+TW-1:0] bkey = '0;
        bit allpos = 1'b1;
        int n = 0;
        for (int k = 0; k < NT; k++) begin
            if (rdy[k]) begin
                n++;
                if (mem[k][TW-1:0] == '0) allpos = 1'b0;
                if (mem[k][TW +: PW] != '0 &&
                    (best < 0 || mem[k][PW+TW-1:0] > bkey)) begin
                    best = k;
                    bkey = mem[k][PW+TW-1:0];
                end
            end
        end
        e.mem = pack_mem();
        e.req = req;
        e.v = (best >= 0);
        e.tid = (best >= 0) ? TW'(best) : '0;
        e.prio = (best >= 0) ? bkey[PW+TW-1:TW] : '0;
        e.acc = (best >= 0) ? 3 * n : n;
        if (best >= 0) begin
            for (int k = 0; k < NT; k++) begin
                if (rdy[k]) begin
                    logic [TW-1:0] w;
                    w = mem[k][TW-1:0];
                    if (allpos) w = w - 1'b1;
                    if (k == best) w = '0;
                    else if (mem[k][TW +: PW] == bkey[PW+TW-1:TW])
                        w = (w == '1) ? w : w + 1'b1;
                    e.mem[k*DW +: TW] = w;
                end
            end
        end else begin
            // sel outputs hold on an empty pass only for valid; tid/prio from last best reset
            e.tid = '0;
            e.prio = '0;
        end
        return e;
    endfunction

    task automatic set_desc(input int k, input logic [DW-1:0] d);
        tb_addr = TW'(k);
        tb_data = d;
        tb_we = 1'b1;
        @(negedge clk);
        tb_we = 1'b0;
    endtask

    task automatic set_ready(input logic [NT-1:0] want);
        rdy_clr = ~want;
        rdy_set = want;
        @(negedge clk);
        rdy_clr = '0;
        rdy_set = '0;
        @(negedge clk);
    endtask

    task automatic run_sched(input string req, input bit disturb);
        exp_q.push_back(model(ready_vec, req));
        run_ready = ready_vec;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (disturb) begin
            @(negedge clk);
            @(negedge clk);
            rdy_set = 8'h40;
            start = 1'b1;
            @(negedge clk);
            rdy_set = '0;
            start = 1'b0;
        end
        while (!done) @(negedge clk);
        @(negedge clk);
    endtask

    // monitor: compare each finished pass with the scoreboard
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R9", "unexpected done", 1, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(sel_valid == e.v, e.req, "sel_valid", sel_valid, e.v);
                if (e.v) begin
                    check(sel_tid == e.tid, e.req, "sel_tid", sel_tid, e.tid);
                    check(sel_prio == e.prio, e.req, "sel_prio", sel_prio, e.prio);
                end
                check(pack_mem() == e.mem, e.req, "descriptor store", pack_mem(), e.mem);
                check((acc_total - acc_mark) == e.acc, "R8", "access count",
                      acc_total - acc_mark, e.acc);
                check(bad_total == bad_mark, "R8", "non-ready access", bad_total - bad_mark, 0);
                acc_mark = acc_total;
                bad_mark = bad_total;
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        n_chk++;
        $display("FAIL R9 watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        for (int k = 0; k < NT; k++) mem[k] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        check(!done && !sel_valid && !mem_en, "R9", "reset outputs",
              {done, sel_valid, mem_en}, 0);
        check(ready_vec == '0, "R1", "reset ready", ready_vec, 0);

        // R1 set, then set+clear together
        rdy_set = 8'h26;
        @(negedge clk);
        rdy_set = '0;
        check(ready_vec == 8'h26, "R1", "set bits", ready_vec, 8'h26);
        rdy_set = 8'h08;
        rdy_clr = 8'h0a;
        @(negedge clk);
        rdy_set = '0;
        rdy_clr = '0;
        check(ready_vec == 8'h24, "R1", "clear wins", ready_vec, 8'h24);

        // R5 nothing ready
        set_ready(8'h00);
        run_sched("R5", 1'b0);

        // R5 only invalid threads ready
        set_desc(5, mk(1'b0, 3'd0, 4'd0, 3'd5));
        set_ready(8'h20);
        run_sched("R5", 1'b0);

        // R2 R4 distinct priorities, link fields preserved
        set_desc(0, mk(1'b0, 3'd2, 4'd3, 3'd1));
        set_desc(3, mk(1'b0, 3'd0, 4'd7, 3'd0));
        set_desc(5, mk(1'b1, 3'd1, 4'd0, 3'd7));
        set_desc(6, mk(1'b1, 3'd4, 4'd5, 3'd2));
        set_ready(8'h69);
        run_sched("R2", 1'b0);
        check(sel_tid == 3'd3, "R4", "invalid high wcnt skipped", sel_tid, 3);

        // R3 tie, R6 increment
        set_desc(1, mk(1'b0, 3'd0, 4'd6, 3'd2));
        set_desc(2, mk(1'b1, 3'd5, 4'd6, 3'd2));
        set_desc(4, mk(1'b0, 3'd0, 4'd6, 3'd0));
        set_ready(8'h16);
        run_sched("R3", 1'b0);
        check(sel_tid == 3'd1, "R3", "lower id on tie", sel_tid, 1);

        // R6 saturation of a peer
        set_desc(1, mk(1'b0, 3'd0, 4'd9, 3'd7));
        set_desc(2, mk(1'b0, 3'd0, 4'd9, 3'd7));
        set_desc(3, mk(1'b0, 3'd0, 4'd9, 3'd0));
        set_ready(8'h0e);
        run_sched("R6", 1'b0);
        check(mem[2][TW-1:0] == 3'd7, "R6", "saturated peer", mem[2][TW-1:0], 7);

        // R7 all positive: global decrement
        set_desc(0, mk(1'b0, 3'd0, 4'd2, 3'd3));
        set_desc(4, mk(1'b0, 3'd0, 4'd2, 3'd1));
        set_desc(7, mk(1'b0, 3'd0, 4'd8, 3'd2));
        set_ready(8'h91);
        run_sched("R7", 1'b0);
        check(mem[0][TW-1:0] == 3'd2, "R7", "decremented other prio", mem[0][TW-1:0], 2);

        // R6 round robin among equal priority
        set_desc(0, mk(1'b0, 3'd0, 4'd4, 3'd0));
        set_desc(4, mk(1'b0, 3'd0, 4'd4, 3'd0));
        set_desc(7, mk(1'b0, 3'd0, 4'd4, 3'd0));
        for (int r = 0; r < 4; r++) run_sched("R6", 1'b0);

        // R10 R9 ready change and second start mid-pass
        set_desc(6, mk(1'b0, 3'd0, 4'd15, 3'd7));
        set_ready(8'h11);
        run_sched("R10", 1'b1);
        check(ready_vec == 8'h51, "R10", "late set visible", ready_vec, 8'h51);
        run_sched("R10", 1'b0);
        check(sel_tid == 3'd6, "R10", "late thread next pass", sel_tid, 6);

        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R9", "one done per start", exp_q.size(), 0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule